// File: doc/BRIEF.md
# Extended Subtract-From-Minus-One Execution Slice

This block is one arithmetic slice of a fixed-point execution pipeline. It takes one source operand and the architectural carry bit. It forms the sum of the operand's bitwise inverse, the all-ones constant and the incoming carry. It returns the truncated result together with the next values of the status state: the carry, overflow and sticky summary-overflow bits of the exception register, and a four-bit condition field.

The flag updates are gated separately. The carry is written by every operation. Overflow and summary-overflow are written only when the overflow-enable control is set. The condition field is written only when the record control is set. Every output is registered on the clock edge that samples an asserted valid strobe. Each write enable is high for exactly that one following cycle, so a register-file or status-register writer can consume the results directly.

Top module: `minus_one_sub_unit`

## Requirements
- R1: For a sampled operand A and carry-in c, the result is (~A + 0xFFFFFFFF + c) mod 2^32. Examples: A=0x90003000, c=1 gives 0x6FFFCFFF; A=0xB0043000, c=0 gives 0x4FFBCFFE; A=0xEFFFFFFF gives 0x10000000 with c=1 and 0x0FFFFFFF with c=0.
- R2: The new carry is bit 32 of that sum taken as a 33-bit addition. The carry and its write enable are produced by every operation, whatever the controls.
- R3: Overflow is signed two's-complement overflow of the sum: ~A interpreted as signed, minus 1, plus c, falls outside the 32-bit signed range.
- R4: When the overflow-enable control is 1, the overflow write enable pulses. When it is 0, that enable stays low and the overflow and summary-overflow outputs keep their earlier values.
- R5: When enabled, the new summary-overflow value is the incoming summary-overflow bit ORed with the new overflow bit. The block never clears a set incoming summary-overflow bit.
- R6: The condition write enable pulses only when the record control is 1. When the control is 0, the enable stays low and the condition output keeps its earlier value.
- R7: The condition field encoding is bit 3 = result negative, bit 2 = result positive, bit 1 = result zero, and bit 0 = the summary-overflow value after this operation's update. Bits 3..1 come from a signed comparison with zero, and exactly one of them is set.
- R8: Outputs update on the rising edge that samples valid high. Each write enable is high for exactly one cycle per operation. With valid low, all enables are low and the data outputs hold.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| opnd_i | input | 32 | Source operand |
| ca_i | input | 1 | Current carry bit |
| so_i | input | 1 | Current summary-overflow bit |
| ovf_en_i | input | 1 | Overflow-enable control |
| rec_i | input | 1 | Record control (condition update) |
| result_o | output | 32 | Registered result |
| res_we_o | output | 1 | Result write enable |
| ca_o | output | 1 | New carry bit |
| ca_we_o | output | 1 | Carry write enable |
| ov_o | output | 1 | New overflow bit |
| so_o | output | 1 | New summary-overflow bit |
| ov_we_o | output | 1 | Overflow/summary-overflow write enable |
| cond_o | output | 4 | New condition field (LT, GT, EQ, SO) |
| cond_we_o | output | 1 | Condition write enable |

## Verification
Every result of an operation is due one clock after the edge that samples valid. The result, carry, overflow, summary-overflow, condition value and all four write enables share that single register stage. The bench drives inputs on the falling edge and computes the expected values from that cycle's inputs with integer arithmetic. It compares them at the next falling edge, which lies just past the capturing rising edge. In idle cycles it checks that every enable is low and that the data outputs still hold the previous operation's values.

// File: rtl/mos_pkg.sv
package mos_pkg;

    localparam int CF_W  = 4;
    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;
    localparam int CF_SO = 0;

    typedef struct packed {
        logic            ca;
        logic            ov;
        logic            so;
        logic [CF_W-1:0] cond;
        logic            res_we;
        logic            ca_we;
        logic            ov_we;
        logic            cond_we;
    } mos_flags_t;

endpackage

// File: rtl/mos_adder.sv
module mos_adder #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opnd_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    localparam logic [DW:0] ALL_ONES = {1'b0, {DW{1'b1}}};

    logic [DW:0] inv_ext;
    logic [DW:0] wide_sum;

    always_comb begin
        inv_ext  = {1'b0, ~opnd_i};
        wide_sum = inv_ext + ALL_ONES + {{DW{1'b0}}, cin_i};
        sum_o    = wide_sum[DW-1:0];
        cout_o   = wide_sum[DW];
        // second addend is negative: overflow only when the inverted
        // operand is negative too and the sum flips to non-negative
        ovf_o    = inv_ext[DW-1] & ~wide_sum[DW-1];
    end
endmodule

// File: rtl/mos_cond.sv
module mos_cond
    import mos_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   res_i,
    input  logic            so_i,
    output logic [CF_W-1:0] cond_o
);
    logic neg, zero;

    always_comb begin
        neg            = res_i[DW-1];
        zero           = (res_i == '0);
        cond_o         = '0;
        cond_o[CF_LT]  = neg;
        cond_o[CF_EQ]  = zero;
        cond_o[CF_GT]  = ~neg & ~zero;
        cond_o[CF_SO]  = so_i;
    end
endmodule

// File: rtl/minus_one_sub_unit.sv
module minus_one_sub_unit
    import mos_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [DW-1:0]   opnd_i,
    input  logic            ca_i,
    input  logic            so_i,
    input  logic            ovf_en_i,
    input  logic            rec_i,
    output logic [DW-1:0]   result_o,
    output logic            res_we_o,
    output logic            ca_o,
    output logic            ca_we_o,
    output logic            ov_o,
    output logic            so_o,
    output logic            ov_we_o,
    output logic [CF_W-1:0] cond_o,
    output logic            cond_we_o
);
    typedef struct packed {
        logic [DW-1:0] res;
        mos_flags_t    fl;
    } st_t;

    st_t st_d, st_q;

    logic [DW-1:0]   sum_w;
    logic            cout_w;
    logic            ovf_w;
    logic            so_upd;
    logic [CF_W-1:0] cond_w;

    mos_adder #(.DW(DW)) u_add (
        .opnd_i (opnd_i),
        .cin_i  (ca_i),
        .sum_o  (sum_w),
        .cout_o (cout_w),
        .ovf_o  (ovf_w)
    );

    assign so_upd = ovf_en_i ? (so_i | ovf_w) : so_i;

    mos_cond #(.DW(DW)) u_cond (
        .res_i  (sum_w),
        .so_i   (so_upd),
        .cond_o (cond_w)
    );

    always_comb begin
        st_d            = st_q;
        st_d.fl.res_we  = 1'b0;
        st_d.fl.ca_we   = 1'b0;
        st_d.fl.ov_we   = 1'b0;
        st_d.fl.cond_we = 1'b0;
        if (valid_i) begin
            st_d.res       = sum_w;
            st_d.fl.res_we = 1'b1;
            st_d.fl.ca     = cout_w;
            st_d.fl.ca_we  = 1'b1;
            if (ovf_en_i) begin
                st_d.fl.ov    = ovf_w;
                st_d.fl.so    = so_upd;
                st_d.fl.ov_we = 1'b1;
            end
            if (rec_i) begin
                st_d.fl.cond    = cond_w;
                st_d.fl.cond_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.res;
    assign res_we_o  = st_q.fl.res_we;
    assign ca_o      = st_q.fl.ca;
    assign ca_we_o   = st_q.fl.ca_we;
    assign ov_o      = st_q.fl.ov;
    assign so_o      = st_q.fl.so;
    assign ov_we_o   = st_q.fl.ov_we;
    assign cond_o    = st_q.fl.cond;
    assign cond_we_o = st_q.fl.cond_we;

    a_r2_carry_every_op: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (ca_we_o && res_we_o));
    a_r3_neg_operand_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ovf_en_i && opnd_i[DW-1]) |=> !ov_o);
    a_r4_ov_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ovf_en_i) |=> !ov_we_o);
    a_r5_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ovf_en_i && so_i) |=> so_o);
    a_r6_cond_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !rec_i) |=> !cond_we_o);
    a_r7_cond_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cond_we_o |-> ($countones(cond_o[CF_LT:CF_EQ]) == 1));
    a_r7_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_we_o && ov_we_o) |-> (cond_o[CF_SO] == so_o));
    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !(res_we_o || ca_we_o || ov_we_o || cond_we_o));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o));
endmodule

// File: tb/minus_one_sub_unit_tb.sv
`timescale 1ns/1ps
module minus_one_sub_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] opnd_i = '0;
    logic        ca_i = 1'b0, so_i = 1'b0, ovf_en_i = 1'b0, rec_i = 1'b0;
    logic [31:0] result_o;
    logic        res_we_o, ca_o, ca_we_o, ov_o, so_o, ov_we_o, cond_we_o;
    logic [3:0]  cond_o;

    int n_chk = 0;
    int n_err = 0;

    // expected state
    bit          pend = 0;
    bit          e_v, e_oe, e_rc;
    logic [31:0] e_res = '0;
    logic        e_ca, e_ov, e_so;
    logic [3:0]  e_cond;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    minus_one_sub_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opnd_i(opnd_i),
        .ca_i(ca_i), .so_i(so_i), .ovf_en_i(ovf_en_i), .rec_i(rec_i),
        .result_o(result_o), .res_we_o(res_we_o), .ca_o(ca_o), .ca_we_o(ca_we_o),
        .ov_o(ov_o), .so_o(so_o), .ov_we_o(ov_we_o), .cond_o(cond_o),
        .cond_we_o(cond_we_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_prev();
        if (!pend) return;
        if (e_v) begin
            chk("R1 result", result_o, e_res);
            chk("R2 carry", {31'b0, ca_o}, {31'b0, e_ca});
            chk("R2 carry we", {31'b0, ca_we_o}, 32'd1);
            chk("R8 result we", {31'b0, res_we_o}, 32'd1);
            chk("R4 ov we", {31'b0, ov_we_o}, {31'b0, e_oe});
            if (e_oe) begin
                chk("R3 overflow", {31'b0, ov_o}, {31'b0, e_ov});
                chk("R5 summary", {31'b0, so_o}, {31'b0, e_so});
            end
            chk("R6 cond we", {31'b0, cond_we_o}, {31'b0, e_rc});
            if (e_rc) chk("R7 cond", {28'b0, cond_o}, {28'b0, e_cond});
        end else begin
            chk("R8 idle enables", {28'b0, res_we_o, ca_we_o, ov_we_o, cond_we_o}, 32'd0);
            chk("R8 idle hold", result_o, e_res);
        end
    endtask

    task automatic step(input logic [31:0] a, input logic c, input logic s,
                        input logic oe, input logic rc, input logic v);
        longint signed sv;
        longint unsigned us;
        @(negedge clk);
        check_prev();
        valid_i = v; opnd_i = a; ca_i = c; so_i = s; ovf_en_i = oe; rec_i = rc;
        e_v = v; e_oe = oe; e_rc = rc;
        if (v) begin
            us    = {32'h0, ~a} + 64'hFFFF_FFFF + {63'h0, c};
            e_res = us[31:0];
            e_ca  = us[32];
            sv    = longint'($signed(~a)) - 1 + longint'(c);
            e_ov  = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
            e_so  = s | e_ov;
            if (!oe) e_so = s;
            e_cond[3] = ($signed(e_res) < 0);
            e_cond[2] = ($signed(e_res) > 0);
            e_cond[1] = (e_res == 0);
            e_cond[0] = e_so;
        end
        pend = 1;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset result", result_o, 32'd0);
        chk("R9 reset flags", {23'b0, ca_o, ca_we_o, ov_o, so_o, ov_we_o, cond_we_o, res_we_o, 2'b0},
            32'd0);
        chk("R9 reset cond", {28'b0, cond_o}, 32'd0);
        rst_n = 1'b1;
        // R1 worked examples
        step(32'h9000_3000, 1, 0, 0, 0, 1);
        step(32'hB004_3000, 0, 0, 0, 1, 1);
        step(32'hEFFF_FFFF, 1, 0, 1, 0, 1);
        step(32'hEFFF_FFFF, 0, 0, 1, 1, 1);
        // R2 carry-out zero case, R7 negative
        step(32'hFFFF_FFFF, 0, 0, 1, 1, 1);
        // R7 zero result
        step(32'hFFFF_FFFF, 1, 0, 1, 1, 1);
        // R3 overflow, R5 set from zero
        step(32'h7FFF_FFFF, 0, 0, 1, 1, 1);
        // R4 overflow case with enable off: outputs must keep old values
        step(32'h7FFF_FFFF, 0, 0, 0, 1, 1);
        step(32'h0, 0, 0, 0, 0, 0);
        // R5 sticky with no new overflow
        step(32'h1234_5678, 1, 1, 1, 1, 1);
        // R6 record off, then idle checks
        step(32'h8000_0000, 0, 0, 1, 0, 1);
        step(32'h0, 0, 0, 0, 0, 0);
        step(32'h0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            a = rng;
            if (rng[9:8] == 2'b00) a = {rng[31], 31'h7FFF_FFFF};
            step(a, rng[3], rng[4], rng[5], rng[6], rng[7] | rng[2]);
        end
        step(32'h0, 0, 0, 0, 0, 0);
        step(32'h0, 0, 0, 0, 0, 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule